// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface. It takes the memory from power-up to an idle state in which it can accept normal commands. It drives the chip-select, row-strobe, column-strobe and write-enable command pins, the bank address and a 12-bit address bus. It does this through one fixed sequence:

1. It holds NOP for a power-up delay.
2. It precharges all banks and waits the precharge recovery time.
3. It issues two auto-refresh commands, each followed by the refresh cycle time.
4. It loads the mode register with a word built from its parameters.
5. After the mode-load recovery time it raises a ready flag.

Every delay is a parameter in clock cycles. A single down-counter times all the waits and is reloaded each time the state machine changes state. The command pins are registered, so each pin value appears one cycle after the state that decides it. Synchronous reset returns the machine to the power-up wait. The normal command path uses the ready flag to know when it may take over the pins.

Top module: `sdramInitSeq`

## Requirements
- R1: While the active-high synchronous reset `rst` is sampled high, the outputs are driven to the following values on the next edge and held there: NOP ({csN,rasN,casN,weN}=4'b0111), `addr`=0, `ba`=0 and `initDone`=0.
- R2: After reset is released, the pins show exactly PWRUP_CYC cycles of NOP. The next cycle carries PRECHARGE ({csN,rasN,casN,weN}=4'b0010) with `addr` bit 10 high, all other `addr` bits zero and `ba`=0, which selects all banks.
- R3: Between the precharge and the first AUTO REFRESH (4'b0001, `addr`=0, `ba`=0) there are exactly T_RP NOP cycles.
- R4: Exactly two AUTO REFRESH commands are issued, with exactly T_RFC NOP cycles between them and another T_RFC NOP cycles after the second one.
- R5: After the second refresh recovery, one LOAD MODE command (4'b0000) is issued with `ba`=0 and the mode word on `addr`. The mode word is laid out as follows:
  - bits 2:0 = BURST_LEN
  - bit 3 = BURST_TYPE
  - bits 6:4 = CAS_LAT
  - bits 8:7 = OP_MODE
  - bit 9 = WRITE_BURST
  - bits 11:10 = 0
- R6: `initDone` rises after exactly T_MRD NOP cycles following the LOAD MODE cycle. Once high it stays high until reset, and the pins carry NOP from then on.
- R7: The pins only ever carry NOP, PRECHARGE, AUTO REFRESH or LOAD MODE. Each command appears only in the order precharge, refresh, refresh, load mode, and once per sequence, except that refresh appears twice as listed.
- R8: Reset asserted at any point, including mid-sequence or after `initDone`, restarts the whole sequence from the power-up wait.
- R9: The sequence is correct when every delay parameter is at its minimum value of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus; carries the all-bank flag and the mode word |
| initDone | output | 1 | High once initialization is complete |

## Verification
The assertions assume the following about the block's inputs:
- The clock is running.
- Every delay parameter is at least 1.
- `rst` is held high for at least one clock edge before each sequence.

Given those assumptions, every command is preceded by a NOP, and `$past` across reset only sees the power-up state. The stimulus touches nothing but `rst`, which it changes only at falling edges. It uses short delay settings, including one instance where every delay is 1, so that whole sequences fit in the run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_PRE,
    ST_TRP,
    ST_REF1,
    ST_RFC1,
    ST_REF2,
    ST_RFC2,
    ST_LMR,
    ST_MRD,
    ST_DONE
  } initState_e;

  typedef enum logic [1:0] {
    DLY_PWRUP,
    DLY_RP,
    DLY_RFC,
    DLY_MRD
  } delaySel_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmdSel_e;

  typedef struct packed {
    logic      loadTimer;
    delaySel_e delaySel;
    cmdSel_e   cmdSel;
    logic      markReady;
  } initStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_LMR = 4'b0000;

  function automatic logic [11:0] buildModeWord(
    input logic [2:0] burstLen,
    input logic       burstType,
    input logic [2:0] casLat,
    input logic [1:0] opMode,
    input logic       writeBurst
  );
    return {2'b00, writeBurst, opMode, casLat, burstType, burstLen};
  endfunction

endpackage

// File: rtl/initCtrl.sv
module initCtrl
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        timerZero,
  output initStrobe_t strobe
);

  initState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_PWRUP;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_PWRUP: if (timerZero) stateNext = ST_PRE;
      ST_PRE:                  stateNext = ST_TRP;
      ST_TRP:   if (timerZero) stateNext = ST_REF1;
      ST_REF1:                 stateNext = ST_RFC1;
      ST_RFC1:  if (timerZero) stateNext = ST_REF2;
      ST_REF2:                 stateNext = ST_RFC2;
      ST_RFC2:  if (timerZero) stateNext = ST_LMR;
      ST_LMR:                  stateNext = ST_MRD;
      ST_MRD:   if (timerZero) stateNext = ST_DONE;
      ST_DONE:                 stateNext = ST_DONE;
      default:                 stateNext = ST_PWRUP;
    endcase
  end

  always_comb begin
    strobe.loadTimer = (stateNext != state);
    unique case (stateNext)
      ST_TRP:           strobe.delaySel = DLY_RP;
      ST_RFC1, ST_RFC2: strobe.delaySel = DLY_RFC;
      ST_MRD:           strobe.delaySel = DLY_MRD;
      default:          strobe.delaySel = DLY_PWRUP;
    endcase
    unique case (state)
      ST_PRE:           strobe.cmdSel = CMD_PRE;
      ST_REF1, ST_REF2: strobe.cmdSel = CMD_REF;
      ST_LMR:           strobe.cmdSel = CMD_LMR;
      default:          strobe.cmdSel = CMD_NOP;
    endcase
    strobe.markReady = (state == ST_DONE);
  end

  logic inWait;
  assign inWait = (state == ST_PWRUP) || (state == ST_TRP) || (state == ST_RFC1) ||
                  (state == ST_RFC2)  || (state == ST_MRD);

  // R3
  ref_after_rp_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REF1) |-> ($past(state) == ST_TRP));

  // R4
  lmr_after_rfc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LMR) |-> ($past(state) == ST_RFC2));

  // R2
  wait_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (inWait && timerZero) |=> (state != $past(state)));

endmodule

// File: rtl/initDatapath.sv
module initDatapath
  import sdram_init_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 9,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned AP_BIT    = 10,
  parameter logic [11:0] MODE_WORD = 12'h030
)(
  input  logic              clk,
  input  logic              rst,
  input  initStrobe_t       strobe,
  output logic              timerZero,
  output logic [3:0]        cmdPins,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int unsigned MAX_A   = (PWRUP_CYC > T_RP)  ? PWRUP_CYC : T_RP;
  localparam int unsigned MAX_B   = (T_RFC > T_MRD)     ? T_RFC     : T_MRD;
  localparam int unsigned MAX_DLY = (MAX_A > MAX_B)     ? MAX_A     : MAX_B;
  localparam int unsigned TMR_W   = $clog2(MAX_DLY + 1);

  localparam logic [TMR_W-1:0] LD_PWRUP = TMR_W'(PWRUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] LD_RFC   = TMR_W'(T_RFC - 1);
  localparam logic [TMR_W-1:0] LD_MRD   = TMR_W'(T_MRD - 1);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MODE_BUS  = ADDR_W'(MODE_WORD);

  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] loadVal;

  always_comb begin
    unique case (strobe.delaySel)
      DLY_RP:  loadVal = LD_RP;
      DLY_RFC: loadVal = LD_RFC;
      DLY_MRD: loadVal = LD_MRD;
      default: loadVal = LD_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   timer <= LD_PWRUP;
    else if (strobe.loadTimer) timer <= loadVal;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdPins  <= PIN_NOP;
      ba       <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      ba <= '0;
      unique case (strobe.cmdSel)
        CMD_PRE: begin cmdPins <= PIN_PRE; addr <= ALL_BANKS; end
        CMD_REF: begin cmdPins <= PIN_REF; addr <= '0;        end
        CMD_LMR: begin cmdPins <= PIN_LMR; addr <= MODE_BUS;  end
        default: begin cmdPins <= PIN_NOP; addr <= '0;        end
      endcase
      if (strobe.markReady) initDone <= 1'b1;
    end
  end

  // R7
  legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdPins == PIN_NOP) || (cmdPins == PIN_PRE) ||
    (cmdPins == PIN_REF) || (cmdPins == PIN_LMR));

  // R2
  nop_before_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdPins != PIN_NOP) |-> ($past(cmdPins) == PIN_NOP));

  // R6
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (cmdPins == PIN_NOP));

  // R5
  lmr_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdPins == PIN_LMR) |-> !initDone);

endmodule

// File: rtl/sdramInitSeq.sv
module sdramInitSeq
  import sdram_init_pkg::*;
#(
  parameter int unsigned PWRUP_CYC   = 20000,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_RFC       = 9,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BA_W        = 2,
  parameter logic [2:0]  BURST_LEN   = 3'b011,
  parameter logic        BURST_TYPE  = 1'b0,
  parameter logic [2:0]  CAS_LAT     = 3'b011,
  parameter logic [1:0]  OP_MODE     = 2'b00,
  parameter logic        WRITE_BURST = 1'b0
)(
  input  logic              clk,
  input  logic              rst,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam logic [11:0] MODE_WORD =
    buildModeWord(BURST_LEN, BURST_TYPE, CAS_LAT, OP_MODE, WRITE_BURST);

  initStrobe_t strobe;
  logic        timerZero;
  logic [3:0]  cmdPins;

  initCtrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .timerZero (timerZero),
    .strobe    (strobe)
  );

  initDatapath #(
    .PWRUP_CYC (PWRUP_CYC),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .T_MRD     (T_MRD),
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .AP_BIT    (10),
    .MODE_WORD (MODE_WORD)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .timerZero (timerZero),
    .cmdPins   (cmdPins),
    .ba        (ba),
    .addr      (addr),
    .initDone  (initDone)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: tb/test_sdramInitSeq.sv
`timescale 1ns/1ps
module test_sdramInitSeq;

  localparam int PA = 40, RPA = 3, RFCA = 7, MRDA = 2;
  localparam logic [11:0] MODEA = 12'h23B;
  localparam logic [11:0] MODEB = 12'h020;
  localparam logic [3:0] MARK = 4'b1111;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] gap;
    logic [11:0] adr;
  } vec_t;

  localparam vec_t TAB_A [5] = '{
    '{4'b0010, 32'(PA),   12'h400},
    '{4'b0001, 32'(RPA),  12'h000},
    '{4'b0001, 32'(RFCA), 12'h000},
    '{4'b0000, 32'(RFCA), MODEA},
    '{MARK,    32'(MRDA), 12'h000}
  };
  localparam vec_t TAB_B [5] = '{
    '{4'b0010, 32'd1, 12'h400},
    '{4'b0001, 32'd1, 12'h000},
    '{4'b0001, 32'd1, 12'h000},
    '{4'b0000, 32'd1, MODEB},
    '{MARK,    32'd1, 12'h000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic csA, rasA, casA, weA, doneA, csB, rasB, casB, weB, doneB;
  logic [1:0] baA, baB;
  logic [11:0] addrA, addrB;

  sdramInitSeq #(.PWRUP_CYC(PA), .T_RP(RPA), .T_RFC(RFCA), .T_MRD(MRDA),
    .BURST_LEN(3'b011), .BURST_TYPE(1'b1), .CAS_LAT(3'b011),
    .OP_MODE(2'b00), .WRITE_BURST(1'b1)) i_sdramInitSeq (
    .clk(clk), .rst(rst), .csN(csA), .rasN(rasA), .casN(casA), .weN(weA),
    .ba(baA), .addr(addrA), .initDone(doneA));

  sdramInitSeq #(.PWRUP_CYC(1), .T_RP(1), .T_RFC(1), .T_MRD(1),
    .BURST_LEN(3'b000), .BURST_TYPE(1'b0), .CAS_LAT(3'b010),
    .OP_MODE(2'b00), .WRITE_BURST(1'b0)) i_sdramInitSeq_min (
    .clk(clk), .rst(rst), .csN(csB), .rasN(rasB), .casN(casB), .weN(weB),
    .ba(baB), .addr(addrB), .initDone(doneB));

  logic selB = 1'b0;
  logic [3:0]  curCmd;
  logic [11:0] curAddr;
  logic [1:0]  curBa;
  logic        curDone;
  assign curCmd  = selB ? {csB, rasB, casB, weB} : {csA, rasA, casA, weA};
  assign curAddr = selB ? addrB : addrA;
  assign curBa   = selB ? baB : baA;
  assign curDone = selB ? doneB : doneA;

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(curCmd == 4'b0111, "R1 cmd", curCmd, 4'b0111);
    check(curAddr == 0 && curBa == 0, "R1 addr/ba", {curBa, curAddr}, 0);
    check(curDone == 1'b0, "R1 initDone", curDone, 0);
    rst = 1'b0;
  endtask

  task automatic walk(input bit useB);
    selB = useB;
    for (int i = 0; i < 5; i++) begin
      vec_t v;
      int gap;
      string tag;
      v = useB ? TAB_B[i] : TAB_A[i];
      gap = 0;
      tag = (i == 0) ? "R2" : (i == 1) ? "R3" : (i == 2) ? "R4" : (i == 3) ? "R5" : "R6";
      if (useB) tag = {tag, "/R9"};
      @(negedge clk);
      if (v.cmd == MARK) begin
        while (!curDone && gap < 1000) begin
          check(curCmd == 4'b0111, {tag, " nop before ready"}, curCmd, 4'b0111);
          gap++; @(negedge clk);
        end
        check(curCmd == 4'b0111, {tag, " nop at ready"}, curCmd, 4'b0111);
      end else begin
        while (curCmd == 4'b0111 && gap < 1000) begin
          check(!curDone, {tag, " ready early"}, curDone, 0);
          gap++; @(negedge clk);
        end
        check(curCmd == v.cmd, {tag, " R7 command"}, curCmd, v.cmd);
        check(curAddr == v.adr, {tag, " addr"}, curAddr, v.adr);
        check(curBa == 2'b00, {tag, " ba"}, curBa, 0);
      end
      check(gap == int'(v.gap), {tag, " gap"}, gap, v.gap);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    selB = 1'b0;
    doReset();
    walk(1'b0);
    // R6: stays ready with NOP
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(curDone && curCmd == 4'b0111, "R6 sticky", {curDone, curCmd}, 5'h17);
    end
    // R8: reset after ready, full restart
    doReset();
    walk(1'b0);
    // R8: reset mid-sequence (inside power-up wait and inside refresh recovery)
    doReset();
    for (int k = 0; k < 20; k++) @(negedge clk);
    doReset();
    walk(1'b0);
    doReset();
    for (int k = 0; k < PA + RPA + 3; k++) @(negedge clk);
    doReset();
    walk(1'b0);
    // R9: minimum-delay instance
    selB = 1'b1;
    doReset();
    walk(1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(curDone && curCmd == 4'b0111, "R9 R6 sticky", {curDone, curCmd}, 5'h17);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule